// File: doc/BRIEF.md
# Oscillator Start-up Sequencer with Shared Settling Counter

This block brings a small controller's clocks up after power-on and after every wake from a low-power state. It drives the enables of three sources (a fast crystal, a slow crystal and a slow internal RC oscillator) and raises a ready flag for each one once it is stable. It releases the processor as soon as the fast clock is trusted and picks the system clock source after wake. It also arbitrates processor requests to move the system clock between sources.

Both crystals settle on one counter. The counter counts edges of whichever crystal it is serving, and it serves the fast crystal first. The slow crystal gets its turn only after the fast one is ready, so the processor can already be running while the slow crystal is still settling. The internal RC oscillator needs no settling count. Two sleep depths are supported. Deep sleep stops everything except the slow sub-clock, and it keeps that only while the watchdog is enabled. Light sleep keeps the sub-clock running. With fast wake enabled, a light-sleep wake can start the processor on the already running sub-clock at once.

Top module: `osc_startup_seq`

## Requirements
- R1: While reset is held, all three ready flags and `cpu_run` are 0 and `sys_src` is 0. Source codes: 0 = fast crystal, 1 = slow crystal, 2 = internal RC.
- R2: The fast crystal's ready flag rises on the clock edge that samples the HS_SST-th `hs_tick` after `hs_on` goes high. Ticks counted start with the first edge after `hs_on` rises. When fast wake is not in use, `cpu_run` rises on that same edge.
- R3: The shared counter starts on the slow crystal only after the fast crystal is ready. Counting begins with the `ls_tick` sampled on the edge after the fast ready flag rises. The slow ready flag rises on the edge that samples the LS_SST-th such tick, and until then the processor runs with the slow ready flag at 0.
- R4: A sleep request with `sleep_deep`=1 and `wdt_en`=0, taken while `cpu_run` is 1, turns off the fast crystal and the sub-clock on the accepting edge and stops `cpu_run`. The ready flags of the disabled sources clear on the next edge. After wake the full fast-then-slow sequence repeats.
- R5: In deep sleep with `wdt_en`=1, the sub-clock stays enabled and its ready flag stays 1, so wake needs only the fast crystal's settling period.
- R6: In light sleep (`sleep_deep`=0) the sub-clock and its ready flag stay on. Without fast wake, `cpu_run` rises exactly when the fast ready flag rises, with `sys_src`=0.
- R7: On a light-sleep wake with `fast_wake_en`=1 and the selected sub-clock ready, `cpu_run` is 1 from the wake edge. On that edge `sys_src` becomes the sub-clock's code (1 or 2), before the fast crystal is ready.
- R8: The internal RC oscillator uses no settling count. `rc_ready` is 1 on the edge after `rc_on` rises, and `sub_rc_sel`=1 selects it as the sub-clock in place of the slow crystal.
- R9: A source switch request (`sw_req` with `sw_src`, honoured while `cpu_run` is 1) to a ready source takes effect on the next edge. A request to a source that is not ready sets `sw_pending`, and the switch then completes on the first edge after that source's ready flag rises.
- R10: A sleep request taken while the fast crystal is still settling aborts its count. After the next wake the fast crystal again needs a full HS_SST ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset, treated as power-on |
| sleep_req | input | 1 | Processor request to enter sleep (pulse) |
| sleep_deep | input | 1 | Sleep depth with the request: 1 deep, 0 light |
| wake_req | input | 1 | Wake event (pulse) |
| wdt_en | input | 1 | Watchdog enabled, keeps sub-clock alive in deep sleep |
| sub_rc_sel | input | 1 | Sub-clock source: 0 slow crystal, 1 internal RC |
| fast_wake_en | input | 1 | Allow light-sleep wake on the sub-clock |
| sw_req | input | 1 | System clock switch request (pulse) |
| sw_src | input | 2 | Requested source code |
| hs_tick | input | 1 | One pulse per fast crystal cycle |
| ls_tick | input | 1 | One pulse per slow crystal cycle |
| hs_on | output | 1 | Fast crystal enable |
| ls_on | output | 1 | Slow crystal enable |
| rc_on | output | 1 | Internal RC enable |
| hs_ready | output | 1 | Fast crystal stable |
| ls_ready | output | 1 | Slow crystal stable |
| rc_ready | output | 1 | Internal RC ready |
| cpu_run | output | 1 | Processor released |
| sys_src | output | 2 | Current system clock source code |
| sw_pending | output | 1 | A switch waits for its source to become ready |

## Verification
The bench runs the settling sequence from power-on, from deep sleep with the watchdog off and on, from light sleep with and without fast wake, and from a sleep that cuts a count short. The slow ticks arrive every third cycle while fast ticks arrive every cycle, so an edge-exact ready time shows whether slow ticks were counted too early or fast ticks too late. It also shows whether the count was reloaded after an abort. Switch requests are made both to ready and to unready sources, which separates an immediate switch from a deferred one by exactly one edge after the ready flag rises.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HS   = 2'd1,
    OWN_LS   = 2'd2
  } sst_owner_e;

  localparam logic [1:0] SRC_HS = 2'd0;
  localparam logic [1:0] SRC_LS = 2'd1;
  localparam logic [1:0] SRC_RC = 2'd2;

  // True when the count already holds period-1, so one more tick completes it.
  function automatic logic sst_last(input int unsigned cnt, input int unsigned period);
    return cnt == period - 1;
  endfunction

  function automatic logic [1:0] sub_src_code(input logic rc_sel);
    return rc_sel ? SRC_RC : SRC_LS;
  endfunction

  // rdy bit 0 fast crystal, bit 1 slow crystal, bit 2 internal RC
  function automatic logic src_ready(input logic [1:0] src, input logic [2:0] rdy);
    case (src)
      SRC_HS:  return rdy[0];
      SRC_LS:  return rdy[1];
      SRC_RC:  return rdy[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/osc_sst_counter.sv
module osc_sst_counter
  import osc_seq_pkg::*;
#(
  parameter int unsigned HS_SST = 1024,
  parameter int unsigned LS_SST = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_need,
  input  logic       ls_need,
  input  logic       hs_tick,
  input  logic       ls_tick,
  output logic       hs_done,
  output logic       ls_done,
  output sst_owner_e owner
);

  localparam int unsigned MAXP = (HS_SST > LS_SST) ? HS_SST : LS_SST;
  localparam int unsigned CW   = $clog2(MAXP + 1);

  sst_owner_e    owner_q;
  logic [CW-1:0] cnt_q, cnt_base, cnt_d;
  logic          tick_c, last_c;
  int unsigned   period_c;

  // Fast crystal always claims the counter first.
  always_comb begin
    if (hs_need)      owner = OWN_HS;
    else if (ls_need) owner = OWN_LS;
    else              owner = OWN_NONE;
  end

  always_comb begin
    cnt_base = (owner != owner_q) ? '0 : cnt_q;
    case (owner)
      OWN_HS:  begin tick_c = hs_tick; period_c = HS_SST; end
      OWN_LS:  begin tick_c = ls_tick; period_c = LS_SST; end
      default: begin tick_c = 1'b0;    period_c = MAXP;   end
    endcase
    last_c = tick_c && sst_last(32'(cnt_base), period_c);
    if (last_c)      cnt_d = '0;
    else if (tick_c) cnt_d = cnt_base + 1'b1;
    else             cnt_d = cnt_base;
  end

  assign hs_done = last_c && (owner == OWN_HS);
  assign ls_done = last_c && (owner == OWN_LS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      cnt_q   <= '0;
    end else begin
      owner_q <= owner;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/osc_clk_switch.sv
module osc_clk_switch
  import osc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       flush,
  input  logic       load,
  input  logic [1:0] load_src,
  input  logic       req,
  input  logic [1:0] req_src,
  input  logic [2:0] rdy,
  output logic [1:0] sys_src,
  output logic       pending
);

  logic [1:0] tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_src <= SRC_HS;
      pending <= 1'b0;
      tgt_q   <= SRC_HS;
    end else if (flush) begin
      pending <= 1'b0;
    end else if (load) begin
      sys_src <= load_src;
      pending <= 1'b0;
    end else if (run && req) begin
      if (src_ready(req_src, rdy)) begin
        sys_src <= req_src;
        pending <= 1'b0;
      end else begin
        tgt_q   <= req_src;
        pending <= 1'b1;
      end
    end else if (pending && src_ready(tgt_q, rdy)) begin
      sys_src <= tgt_q;
      pending <= 1'b0;
    end
  end

  // R9: outside a wake load, the source only moves to one that was ready.
  assert_switch_to_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_src != $past(sys_src) && !$past(load)) |-> src_ready(sys_src, $past(rdy)));

endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq
  import osc_seq_pkg::*;
#(
  parameter int unsigned HS_SST = 1024,
  parameter int unsigned LS_SST = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       sleep_deep,
  input  logic       wake_req,
  input  logic       wdt_en,
  input  logic       sub_rc_sel,
  input  logic       fast_wake_en,
  input  logic       sw_req,
  input  logic [1:0] sw_src,
  input  logic       hs_tick,
  input  logic       ls_tick,
  output logic       hs_on,
  output logic       ls_on,
  output logic       rc_on,
  output logic       hs_ready,
  output logic       ls_ready,
  output logic       rc_ready,
  output logic       cpu_run,
  output logic [1:0] sys_src,
  output logic       sw_pending
);

  logic       asleep_q, deep_q, fast_q;
  logic       sub_on, sub_ready, fast_ok;
  logic       sleep_go, wake_go;
  logic       hs_need, ls_need, hs_done, ls_done;
  logic [1:0] wake_src;
  sst_owner_e owner;

  // Power mode and enables
  assign sub_on    = !asleep_q || !deep_q || wdt_en;
  assign hs_on     = !asleep_q;
  assign ls_on     = sub_on && !sub_rc_sel;
  assign rc_on     = sub_on && sub_rc_sel;
  assign sub_ready = sub_rc_sel ? rc_ready : ls_ready;
  assign fast_ok   = !deep_q && fast_wake_en && sub_ready;
  assign cpu_run   = !asleep_q && (hs_ready || fast_q);
  assign sleep_go  = sleep_req && cpu_run;
  assign wake_go   = wake_req && asleep_q && !hs_ready;
  assign wake_src  = fast_ok ? sub_src_code(sub_rc_sel) : SRC_HS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      deep_q   <= 1'b1;
      fast_q   <= 1'b0;
    end else if (sleep_go) begin
      asleep_q <= 1'b1;
      deep_q   <= sleep_deep;
      fast_q   <= 1'b0;
    end else if (wake_go) begin
      asleep_q <= 1'b0;
      fast_q   <= fast_ok;
    end
  end

  // Shared settling counter
  assign hs_need = hs_on && !hs_ready;
  assign ls_need = ls_on && !ls_ready;

  osc_sst_counter #(.HS_SST(HS_SST), .LS_SST(LS_SST)) u_sst (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_need (hs_need),
    .ls_need (ls_need),
    .hs_tick (hs_tick),
    .ls_tick (ls_tick),
    .hs_done (hs_done),
    .ls_done (ls_done),
    .owner   (owner)
  );

  // Ready flags: set by the counter, dropped when the source is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_ready <= 1'b0;
      ls_ready <= 1'b0;
      rc_ready <= 1'b0;
    end else begin
      hs_ready <= hs_on && (hs_ready || hs_done);
      ls_ready <= ls_on && (ls_ready || ls_done);
      rc_ready <= rc_on;
    end
  end

  osc_clk_switch u_sw (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cpu_run),
    .flush    (sleep_go),
    .load     (wake_go),
    .load_src (wake_src),
    .req      (sw_req),
    .req_src  (sw_src),
    .rdy      ({rc_ready, ls_ready, hs_ready}),
    .sys_src  (sys_src),
    .pending  (sw_pending)
  );

  // R2: without fast wake, release coincides with the fast ready flag rising.
  assert_release_on_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_run) && !fast_q) |-> $rose(hs_ready));

  // R3: the slow crystal never finishes while the fast one still needs the counter.
  assert_ls_after_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_ready) |-> (hs_ready || !hs_on));

  // R4: a disabled fast crystal loses its ready flag on the next edge.
  assert_hs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_on |=> !hs_ready);

  // R5: an enabled, stable slow crystal stays ready.
  assert_ls_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_ready && ls_on) |=> (ls_ready || !ls_on));

  // R8: the internal RC is ready one edge after it is enabled.
  assert_rc_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_on) |=> rc_ready);

endmodule

// File: tb/tb_osc_startup_seq.sv
module tb_osc_startup_seq;

  localparam int HS_N = 8;
  localparam int LS_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, sleep_deep = 0, wake_req = 0, wdt_en = 0;
  logic sub_rc_sel = 0, fast_wake_en = 0, sw_req = 0;
  logic [1:0] sw_src = 0;
  logic hs_tick = 1'b1, ls_tick = 1'b0;
  logic hs_on, ls_on, rc_on, hs_ready, ls_ready, rc_ready, cpu_run, sw_pending;
  logic [1:0] sys_src;

  int cyc = 0;
  int checks = 0;
  int errs = 0;

  always #2 clk = ~clk;

  osc_startup_seq #(.HS_SST(HS_N), .LS_SST(LS_N)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
    .wake_req(wake_req), .wdt_en(wdt_en), .sub_rc_sel(sub_rc_sel),
    .fast_wake_en(fast_wake_en), .sw_req(sw_req), .sw_src(sw_src),
    .hs_tick(hs_tick), .ls_tick(ls_tick), .hs_on(hs_on), .ls_on(ls_on),
    .rc_on(rc_on), .hs_ready(hs_ready), .ls_ready(ls_ready), .rc_ready(rc_ready),
    .cpu_run(cpu_run), .sys_src(sys_src), .sw_pending(sw_pending)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Slow crystal tick is seen by edge e exactly when e is a multiple of 3.
  always @(negedge clk) ls_tick = ((cyc + 1) % 3 == 0);

  function automatic int ls_expect(input int start);
    int e = start;
    int n = 0;
    while (n < LS_N) begin
      e++;
      if (e % 3 == 0) n++;
    end
    return e;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sel(input int which);
    case (which)
      0: return hs_ready;
      1: return ls_ready;
      default: return cpu_run;
    endcase
  endfunction

  task automatic wait_rise(input int which, output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sel(which)) begin at = cyc; break; end
    end
  endtask

  task automatic do_sleep(input logic deep, output int at);
    sleep_deep = deep; sleep_req = 1;
    @(negedge clk);
    sleep_req = 0; at = cyc;
  endtask

  task automatic do_wake(output int at);
    wake_req = 1;
    @(negedge clk);
    wake_req = 0; at = cyc;
  endtask

  task automatic do_switch(input logic [1:0] s);
    sw_src = s; sw_req = 1;
    @(negedge clk);
    sw_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int h, l, w, s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hs_ready", hs_ready, 0);
    chk("R1 ls_ready", ls_ready, 0);
    chk("R1 cpu_run", cpu_run, 0);
    chk("R1 sys_src", sys_src, 0);
    rst_n = 1;

    // R2/R3 power-on sequence and deferred switch
    wait_rise(0, h);
    chk("R2 hs rise edge", h, HS_N);
    chk("R2 cpu_run with hs", cpu_run, 1);
    chk("R3 ls not ready at release", ls_ready, 0);
    do_switch(2'd1);
    chk("R9 pending on unready", sw_pending, 1);
    chk("R9 src held", sys_src, 0);
    wait_rise(1, l);
    chk("R3 ls rise edge", l, ls_expect(h));
    chk("R9 src before rise+1", sys_src, 0);
    @(negedge clk);
    chk("R9 src after rise+1", sys_src, 1);
    chk("R9 pending cleared", sw_pending, 0);
    do_switch(2'd0);
    chk("R9 immediate switch", sys_src, 0);

    // R4 deep sleep, watchdog off
    do_sleep(1, s);
    chk("R4 cpu stopped", cpu_run, 0);
    chk("R4 hs_on off", hs_on, 0);
    chk("R4 ls_on off", ls_on, 0);
    @(negedge clk);
    chk("R4 hs_ready cleared", hs_ready, 0);
    chk("R4 ls_ready cleared", ls_ready, 0);
    repeat (3) @(negedge clk);
    do_wake(w);
    wait_rise(0, h);
    chk("R4 hs rise after wake", h, w + HS_N);
    wait_rise(1, l);
    chk("R4 ls rise after wake", l, ls_expect(h));

    // R5 deep sleep, watchdog on
    wdt_en = 1;
    do_sleep(1, s);
    @(negedge clk);
    chk("R5 ls_on kept", ls_on, 1);
    chk("R5 ls_ready kept", ls_ready, 1);
    do_wake(w);
    wait_rise(0, h);
    chk("R5 hs rise", h, w + HS_N);
    chk("R5 ls still ready", ls_ready, 1);

    // R6 light sleep, no fast wake
    wdt_en = 0;
    do_sleep(0, s);
    repeat (2) @(negedge clk);
    chk("R6 ls kept in light", ls_ready, 1);
    do_wake(w);
    chk("R6 cpu held at wake", cpu_run, 0);
    wait_rise(2, h);
    chk("R6 release edge", h, w + HS_N);
    chk("R6 src fast", sys_src, 0);

    // R7 light sleep with fast wake, then R9 switch to unready fast crystal
    fast_wake_en = 1;
    do_sleep(0, s);
    repeat (2) @(negedge clk);
    do_wake(w);
    chk("R7 cpu at wake", cpu_run, 1);
    chk("R7 src sub", sys_src, 1);
    chk("R7 hs not ready", hs_ready, 0);
    do_switch(2'd0);
    chk("R9 pending to hs", sw_pending, 1);
    wait_rise(0, h);
    chk("R7 hs rise", h, w + HS_N);
    chk("R9 src before", sys_src, 1);
    @(negedge clk);
    chk("R9 src after", sys_src, 0);

    // R10 abort of fast count
    do_sleep(0, s);
    repeat (2) @(negedge clk);
    do_wake(w);
    repeat (2) @(negedge clk);
    wdt_en = 1;
    do_sleep(1, s);
    chk("R10 hs not ready", hs_ready, 0);
    repeat (4) @(negedge clk);
    do_wake(w);
    chk("R10 cpu held", cpu_run, 0);
    wait_rise(0, h);
    chk("R10 full period", h, w + HS_N);
    chk("R10 cpu run", cpu_run, 1);

    // R8 internal RC
    wdt_en = 0;
    sub_rc_sel = 1;
    #0;
    chk("R8 rc_on", rc_on, 1);
    chk("R8 ls_on off", ls_on, 0);
    chk("R8 rc not yet", rc_ready, 0);
    @(negedge clk);
    chk("R8 rc ready", rc_ready, 1);
    chk("R8 ls cleared", ls_ready, 0);
    do_sleep(0, s);
    repeat (2) @(negedge clk);
    do_wake(w);
    chk("R7 rc src", sys_src, 2);
    chk("R7 rc cpu", cpu_run, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule